// File: doc/BRIEF.md
# Physical Write Protection Unit

This block sits between the address path and the memory write strobe and decides, for every physical write, whether the write may proceed. The physical address space is divided into equal coarse blocks, each with its own protect bit. Up to a parameterised number of those blocks (two by default) can also be refined: a selector picks the block, and a mask holds one protect bit for each of its smaller sub-blocks. A write to a protected region is blocked in the cycle the strobe is asserted, and a write-protect interrupt request is raised.

Enforcement can cover every write, or only writes made in user mode. The interrupt request is sticky and is presented at a fixed priority level. Software clears it with an acknowledge pulse. Further violations while the request is pending do not queue anything extra. Reads never pass through this block, and nothing is blocked while the write strobe is low.

Top module: `wp_unit`

## Requirements
- R1: After reset, `irq_req` is 0, and it rises only in the cycle after a blocked write.
- R2: `wr_inhibit` is 0 whenever `wr_stb` is 0, whatever the address and configuration.
- R3: The coarse block index is `wr_addr[19:16]`. Bit n of `cfg_blk_mask` protects block n, and an enforced write to a block whose bit is set drives `wr_inhibit` high in the same cycle.
- R4: Refined region k is selected by `cfg_fine_sel[4k+3:4k]`. Within the selected block, the sub-block index is `wr_addr[15:12]`, and bit j of `cfg_fine_mask[16k+15:16k]` protects sub-block j. An enforced write to a protected sub-block is inhibited.
- R5: The sub-block bits of a refined region have no effect on writes outside the block that region selects.
- R6: The final decision is the OR of the coarse bit and both refined regions. If both selectors name the same block, their masks combine.
- R7: With `cfg_user_only`=1, writes with `user_mode`=0 (system) are never inhibited and writes with `user_mode`=1 are checked. With `cfg_user_only`=0, writes in both modes are checked.
- R8: A blocked write sets `irq_req` at the next clock edge.
- R9: `irq_req` stays high until a cycle with `irq_ack`=1. A cycle with `irq_ack`=1 and no blocked write clears it at the next edge.
- R10: When a blocked write and `irq_ack` fall in the same cycle, `irq_req` is 1 after that edge, so the new violation is not lost.
- R11: `irq_level` always presents priority 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_addr | input | 20 | Physical address of the current access |
| wr_stb | input | 1 | Write strobe for the current cycle |
| user_mode | input | 1 | 1 = user privilege, 0 = system privilege |
| cfg_user_only | input | 1 | 1 = enforce in user mode only, 0 = enforce in all modes |
| cfg_blk_mask | input | 16 | One protect bit per 64 KB block |
| cfg_fine_sel | input | 8 | Block index for each of the two refined regions |
| cfg_fine_mask | input | 32 | One protect bit per 4 KB sub-block, 16 bits per refined region |
| irq_ack | input | 1 | Software acknowledge of the interrupt request |
| wr_inhibit | output | 1 | Blocks the memory write strobe |
| irq_req | output | 1 | Sticky write-protect interrupt request |
| irq_level | output | 2 | Fixed priority of the request |

## Verification
Two functions can coincide in a single cycle: the software acknowledge that clears the pending request, and a new blocked write that sets it. The bench provokes this by issuing a protected write while holding `irq_ack` high, both from a pending and from an idle request state. The request must read 1 after that edge. Reference-model runs with random configurations also produce the same coincidence by chance, and every cycle is compared against the model.

// File: rtl/wp_pkg.sv
package wp_pkg;

   // Priority level presented with every write-protect request
   localparam int unsigned IRQ_LEVEL_W = 2;
   localparam logic [IRQ_LEVEL_W-1:0] IRQ_LEVEL = 2'd3;

   // Enforcement scope selected by configuration
   typedef enum logic {
      ENF_ALL_MODES = 1'b0,
      ENF_USER_ONLY = 1'b1
   } enforce_scope_e;

   // Privilege of the current access
   typedef enum logic {
      PRIV_SYSTEM = 1'b0,
      PRIV_USER   = 1'b1
   } priv_e;

   // Decide whether protection applies to an access of given privilege
   function automatic logic scope_applies(enforce_scope_e scope, priv_e priv);
      logic r;
      case (scope)
         ENF_USER_ONLY: r = (priv == PRIV_USER);
         default:       r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/wp_coarse.sv
module wp_coarse #(
   parameter int unsigned BLK_W = 4,
   parameter int unsigned NBLK  = 16
) (
   input  logic [BLK_W-1:0] blk_idx,
   input  logic [NBLK-1:0]  blk_mask,
   output logic             hit
);

   localparam int unsigned FULL_SPAN = 1 << BLK_W;

   if (NBLK > FULL_SPAN) begin : g_bad
      $error("wp_coarse: NBLK exceeds the index range");
   end

   if (NBLK == FULL_SPAN) begin : g_full
      // Every index value names a real block
      always_comb hit = blk_mask[blk_idx];
   end else begin : g_partial
      // Indices beyond the populated blocks are never protected
      always_comb begin
         hit = 1'b0;
         for (int b = 0; b < int'(NBLK); b++) begin
            if (int'(blk_idx) == b) hit = blk_mask[b];
         end
      end
   end

endmodule

// File: rtl/wp_fine.sv
module wp_fine #(
   parameter int unsigned BLK_W = 4,
   parameter int unsigned SUB_W = 4
) (
   input  logic [BLK_W-1:0]      blk_idx,
   input  logic [SUB_W-1:0]      sub_idx,
   input  logic [BLK_W-1:0]      sel,
   input  logic [(1<<SUB_W)-1:0] sub_mask,
   output logic                  hit
);

   localparam int unsigned NSUB = 1 << SUB_W;

   if (SUB_W == 0) begin : g_bad
      $error("wp_fine: SUB_W must be at least 1");
   end

   logic in_region;
   logic sub_bit;

   always_comb begin
      in_region = (blk_idx == sel);
      sub_bit   = sub_mask[sub_idx];
      hit       = in_region & sub_bit;
   end

   // NSUB documents the mask size
   if (NSUB < 2) begin : g_bad_nsub
      $error("wp_fine: at least two sub-blocks are required");
   end

endmodule

// File: rtl/wp_irq_latch.sv
module wp_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic viol_i,
   input  logic ack_i,
   output logic req_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o <= 1'b0;
      end else if (viol_i) begin
         // a new violation wins over a simultaneous acknowledge
         req_o <= 1'b1;
      end else if (ack_i) begin
         req_o <= 1'b0;
      end
   end

   a_r8_req_after_violation: assert property (@(posedge clk) disable iff (!rst_n)
      viol_i |=> req_o);

   a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> req_o);

   a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !viol_i) |=> !req_o);

   a_r10_collision_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && viol_i && req_o) |=> req_o);

   a_r1_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(viol_i));

endmodule

// File: rtl/wp_unit.sv
module wp_unit
   import wp_pkg::*;
#(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned BLK_W    = 4,
   parameter int unsigned SUB_W    = 4,
   parameter int unsigned NUM_FINE = 2,
   localparam int unsigned NBLK    = 1 << BLK_W,
   localparam int unsigned NSUB    = 1 << SUB_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic                          wr_stb,
   input  logic                          user_mode,
   input  logic                          cfg_user_only,
   input  logic [NBLK-1:0]               cfg_blk_mask,
   input  logic [NUM_FINE*BLK_W-1:0]     cfg_fine_sel,
   input  logic [NUM_FINE*NSUB-1:0]      cfg_fine_mask,
   input  logic                          irq_ack,
   output logic                          wr_inhibit,
   output logic                          irq_req,
   output logic [IRQ_LEVEL_W-1:0]        irq_level
);

   localparam int unsigned BLK_SHIFT = ADDR_W - BLK_W;
   localparam int unsigned SUB_SHIFT = BLK_SHIFT - SUB_W;

   if (ADDR_W <= BLK_W + SUB_W) begin : g_bad_addr
      $error("wp_unit: address too narrow for block and sub-block fields");
   end
   if (NUM_FINE == 0) begin : g_bad_fine
      $error("wp_unit: at least one refined region is required");
   end

   logic [BLK_W-1:0]    blk_idx;
   logic [SUB_W-1:0]    sub_idx;
   logic                coarse_hit;
   logic [NUM_FINE-1:0] fine_hit;
   logic                enforce;
   logic                violation;

   assign blk_idx = BLK_W'(wr_addr >> BLK_SHIFT);
   assign sub_idx = SUB_W'(wr_addr >> SUB_SHIFT);

   wp_coarse #(
      .BLK_W (BLK_W),
      .NBLK  (NBLK)
   ) u_coarse (
      .blk_idx  (blk_idx),
      .blk_mask (cfg_blk_mask),
      .hit      (coarse_hit)
   );

   for (genvar k = 0; k < NUM_FINE; k++) begin : g_fine
      wp_fine #(
         .BLK_W (BLK_W),
         .SUB_W (SUB_W)
      ) u_fine (
         .blk_idx  (blk_idx),
         .sub_idx  (sub_idx),
         .sel      (cfg_fine_sel[k*BLK_W +: BLK_W]),
         .sub_mask (cfg_fine_mask[k*NSUB +: NSUB]),
         .hit      (fine_hit[k])
      );

      a_r5_fine_outside_region: assert property (@(posedge clk) disable iff (!rst_n)
         (blk_idx != cfg_fine_sel[k*BLK_W +: BLK_W]) |-> !fine_hit[k]);
   end

   always_comb begin
      enforce    = scope_applies(enforce_scope_e'(cfg_user_only), priv_e'(user_mode));
      violation  = wr_stb & enforce & (coarse_hit | (|fine_hit));
      wr_inhibit = violation;
   end

   wp_irq_latch u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .viol_i (violation),
      .ack_i  (irq_ack),
      .req_o  (irq_req)
   );

   assign irq_level = IRQ_LEVEL;

   a_r2_read_never_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |-> !wr_inhibit);

   a_r7_system_exempt: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_user_only && !user_mode) |-> !wr_inhibit);

   a_r3_coarse_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !cfg_user_only && coarse_hit) |-> wr_inhibit);

   a_r8_inhibit_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inhibit |=> irq_req);

endmodule

// File: tb/wp_unit_test.sv
module wp_unit_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [19:0] wr_addr;
   logic        wr_stb;
   logic        user_mode;
   logic        cfg_user_only;
   logic [15:0] cfg_blk_mask;
   logic [7:0]  cfg_fine_sel;
   logic [31:0] cfg_fine_mask;
   logic        irq_ack;
   logic        wr_inhibit;
   logic        irq_req;
   logic [1:0]  irq_level;

   int checks = 0;
   int fails  = 0;
   logic exp_irq = 1'b0;
   string cur_tag = "R1";
   bit finished = 0;

   always #2.5 clk = ~clk;  // 200 MHz

   wp_unit uut (
      .clk, .rst_n, .wr_addr, .wr_stb, .user_mode, .cfg_user_only,
      .cfg_blk_mask, .cfg_fine_sel, .cfg_fine_mask, .irq_ack,
      .wr_inhibit, .irq_req, .irq_level
   );

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: arithmetic on the address, no structural copy
   function automatic logic model_inhibit();
      int blk, sub;
      logic hit;
      blk = int'(wr_addr) / 65536;
      sub = (int'(wr_addr) % 65536) / 4096;
      hit = cfg_blk_mask[blk];
      for (int k = 0; k < 2; k++) begin
         if (int'(cfg_fine_sel[k*4 +: 4]) == blk && cfg_fine_mask[k*16 + sub]) hit = 1'b1;
      end
      if (cfg_user_only && !user_mode) hit = 1'b0;
      return wr_stb && hit;
   endfunction

   // One cycle: drive, compare combinational output, clock, compare request
   task automatic cyc(input logic stb, input logic [19:0] a, input logic um, input logic ack);
      logic ei;
      string itag;
      wr_stb = stb; wr_addr = a; user_mode = um; irq_ack = ack;
      #1;
      ei = model_inhibit();
      check(wr_inhibit === ei, cur_tag, int'(wr_inhibit), int'(ei));
      check(irq_level === 2'd3, "R11", int'(irq_level), 3);
      if (ei && ack)        itag = "R10";
      else if (ei)          itag = "R8";
      else if (ack || exp_irq) itag = "R9";
      else                  itag = "R1";
      @(posedge clk);
      exp_irq = ei | (exp_irq & ~ack);
      @(negedge clk);
      check(irq_req === exp_irq, itag, int'(irq_req), int'(exp_irq));
   endtask

   initial begin
      #(1_000_000);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; user_mode = 1'b0; irq_ack = 1'b0;
      cfg_user_only = 1'b0; cfg_blk_mask = 16'h0020;
      cfg_fine_sel = {4'd9, 4'd4}; cfg_fine_mask = {16'h8002, 16'h00A1};
      repeat (3) @(negedge clk);
      // R1: reset state
      check(irq_req === 1'b0, "R1", int'(irq_req), 0);
      check(wr_inhibit === 1'b0, "R1", int'(wr_inhibit), 0);
      rst_n = 1'b1;

      cur_tag = "R2";
      cyc(1'b0, 20'h5_0000, 1'b1, 1'b0);
      cyc(1'b0, 20'h4_0000, 1'b0, 1'b0);

      cur_tag = "R3";
      cyc(1'b1, 20'h5_1234, 1'b0, 1'b0);
      cyc(1'b1, 20'h6_0000, 1'b0, 1'b1);
      cyc(1'b1, 20'h5_FFFF, 1'b1, 1'b1);

      cur_tag = "R4";
      cyc(1'b1, 20'h4_0000, 1'b0, 1'b1);
      cyc(1'b1, 20'h4_1000, 1'b0, 1'b1);
      cyc(1'b1, 20'h4_5ABC, 1'b0, 1'b1);
      cyc(1'b1, 20'h9_F000, 1'b0, 1'b1);
      cyc(1'b1, 20'h9_1FFF, 1'b0, 1'b1);

      cur_tag = "R5";
      cyc(1'b1, 20'h3_0000, 1'b0, 1'b1);
      cyc(1'b1, 20'hA_5000, 1'b0, 1'b1);

      cur_tag = "R6";
      cfg_fine_sel = {4'd4, 4'd4}; cfg_fine_mask = {16'h0002, 16'h00A1};
      cyc(1'b1, 20'h4_1000, 1'b0, 1'b1);
      cyc(1'b1, 20'h4_2000, 1'b0, 1'b1);

      cur_tag = "R7";
      cfg_user_only = 1'b1;
      cyc(1'b1, 20'h5_0000, 1'b0, 1'b1);
      cyc(1'b1, 20'h5_0000, 1'b1, 1'b1);
      cfg_user_only = 1'b0;
      cyc(1'b1, 20'h5_0000, 1'b0, 1'b1);

      cur_tag = "R9";
      cyc(1'b0, 20'h0, 1'b0, 1'b0);
      cyc(1'b0, 20'h0, 1'b0, 1'b0);
      cyc(1'b0, 20'h0, 1'b0, 1'b1);

      cur_tag = "R10";
      cyc(1'b1, 20'h5_0000, 1'b0, 1'b1);
      cyc(1'b1, 20'h5_0000, 1'b0, 1'b1);
      cyc(1'b0, 20'h0, 1'b0, 1'b1);

      cur_tag = "R6";
      for (int n = 0; n < 600; n++) begin
         if (n % 25 == 0) begin
            cfg_blk_mask  = 16'($urandom);
            cfg_fine_sel  = 8'($urandom);
            cfg_fine_mask = $urandom;
            cfg_user_only = 1'($urandom);
         end
         cyc(1'($urandom), 20'($urandom), 1'($urandom), ($urandom % 4) == 0);
      end

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule